// File: doc/BRIEF.md
# Audio Preamplifier Control Register Slave

This block receives control settings for an audio preamplifier over a two-wire serial bus. It accepts write transfers only, at one fixed device address, and stores the bytes in a bank of eight byte-wide registers. The SCL and SDA lines are oversampled on the system clock. START and STOP conditions and SCL edges are recovered from the sampled lines. The block acknowledges each accepted byte by pulling SDA low.

Each transfer has three parts: an address byte, then a pointer byte, then any number of data bytes. The low three bits of the pointer byte choose the first register to write. The pointer steps forward after every data byte, so a whole bank can be loaded in one transfer. The stored bytes are split into the settings the analog path uses: master volume, loudness enable, zero-cross mute mode, four per-output attenuations, bass, treble, general mute and input source. A one-cycle strobe with the register index marks each write. The asynchronous reset doubles as the power-on reset. While it is held, the receiver is idle and general mute reads 1.

Top module: `audio_fader_i2c_slave`

## Requirements
- R1: While reset is held and just after it is released, every setting reads 0, with two exceptions: general mute reads 1 and loudness enable reads 1 (the loudness-off bit is 0). SDA is released and the write strobe is low.
- R2: The block acknowledges the address byte 0x80. For any other address byte it acknowledges nothing and writes nothing until the next START.
- R3: The block acknowledges the pointer byte. Bits 2:0 of that byte pick the register (0 volume, 1 front right, 2 front left, 3 rear right, 4 rear left, 5 bass, 6 treble, 7 switch). Bits 7:3 are ignored.
- R4: The block acknowledges every data byte and stores it in the register the pointer selects.
- R5: The pointer increases by one after each data byte, and register 7 is followed by register 0.
- R6: In register 0, bit 7 drives zc_mode_o, bit 6 set turns loudness off (loud_en_o low), and bits 5:0 drive volume_o.
- R7: The four attenuation outputs each take bits 5:0 of their register. bass_o and treble_o take bits 4:0 of registers 5 and 6.
- R8: In register 7, bit 7 drives gen_mute_o and bits 2:0 drive src_sel_o.
- R9: A STOP or a repeated START ends the transfer and releases SDA. Registers already written keep their values. Bytes clocked after a STOP are neither acknowledged nor stored. After a repeated START the next byte is treated as an address byte.
- R10: Reset applied during a transfer forces general mute to 1, returns the receiver to idle and releases SDA.
- R11: For each stored byte, wr_pulse_o is high for exactly one cycle. In that cycle wr_addr_o gives the register index and the outputs already show the new value.
- R12: The block changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset, also power-on reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| volume_o | output | 6 | Master volume code |
| loud_en_o | output | 1 | Loudness contour enabled |
| zc_mode_o | output | 1 | Mute switching waits for zero crossing |
| fader_fr_o | output | 6 | Front right attenuation |
| fader_fl_o | output | 6 | Front left attenuation |
| fader_rr_o | output | 6 | Rear right attenuation |
| fader_rl_o | output | 6 | Rear left attenuation |
| bass_o | output | 5 | Bass setting |
| treble_o | output | 5 | Treble setting |
| gen_mute_o | output | 1 | General mute |
| src_sel_o | output | 3 | Input source select |
| wr_pulse_o | output | 1 | One-cycle strobe per stored byte |
| wr_addr_o | output | 3 | Index of the register just written |

## Verification
The bench targets these corner cases, and each one exposes a specific fault:
- A burst that runs past register 7: a pointer that saturates or spills into a fourth bit would write the wrong register, or nothing.
- A pointer byte with its upper bits set: a design that decodes those bits would write nothing, or the wrong entry.
- A foreign address byte, and bytes clocked after a STOP: a receiver that does not go deaf would acknowledge them or overwrite settings.
- A reset in the middle of a byte: a design that does not clear general mute and release SDA would leave the outputs live or hang the bus.

The bench also compares every decoded field against its bit positions. This catches swapped loudness and zero-cross bits and wrong field widths.

// File: rtl/audio_i2c_pkg.sv
package audio_i2c_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned VOL_W    = 6;
  localparam int unsigned FADER_W  = 6;
  localparam int unsigned TONE_W   = 5;
  localparam int unsigned SRC_W    = 3;

  localparam int unsigned REG_VOL  = 0;
  localparam int unsigned REG_FR   = 1;
  localparam int unsigned REG_FL   = 2;
  localparam int unsigned REG_RR   = 3;
  localparam int unsigned REG_RL   = 4;
  localparam int unsigned REG_BASS = 5;
  localparam int unsigned REG_TREB = 6;
  localparam int unsigned REG_SW   = 7;
  localparam int unsigned MUTE_BIT = 7;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK, RX_SKIP} rx_state_e;
  typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA} rx_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[MSB];
      sda_d <= sda_q[MSB];
    end
  end

  assign scl_s_o    = scl_q[MSB];
  assign sda_s_o    = sda_q[MSB];
  assign scl_rise_o = scl_q[MSB] & ~scl_d;
  assign scl_fall_o = ~scl_q[MSB] & scl_d;
  // data edges while clock stays high
  assign start_o    = scl_q[MSB] & scl_d & sda_d & ~sda_q[MSB];
  assign stop_o     = scl_q[MSB] & scl_d & ~sda_d & sda_q[MSB];
endmodule

// File: rtl/i2c_write_rx.sv
module i2c_write_rx
  import audio_i2c_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PTR_W    = 3,
  parameter logic [7:0]  DEV_ADDR = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [PTR_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  rx_state_e         state_q;
  rx_phase_e         phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              byte_full;

  assign byte_full = (bit_cnt_q == CNT_W'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_i) begin
        state_q   <= RX_BITS;
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= RX_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          RX_BITS: begin
            if (scl_rise_i && !byte_full) begin
              shreg_q   <= {shreg_q[DATA_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            end else if (scl_fall_i && byte_full) begin
              bit_cnt_q <= '0;
              unique case (phase_q)
                PH_ADDR: begin
                  if (shreg_q == DATA_W'(DEV_ADDR)) begin
                    sda_oe_o <= 1'b1;
                    state_q  <= RX_ACK;
                  end else begin
                    state_q <= RX_SKIP;
                  end
                end
                PH_PTR: begin
                  ptr_q    <= shreg_q[PTR_W-1:0];
                  sda_oe_o <= 1'b1;
                  state_q  <= RX_ACK;
                end
                default: begin
                  wr_stb_o  <= 1'b1;
                  wr_idx_o  <= ptr_q;
                  wr_data_o <= shreg_q;
                  ptr_q     <= ptr_q + PTR_W'(1);
                  sda_oe_o  <= 1'b1;
                  state_q   <= RX_ACK;
                end
              endcase
            end
          end
          RX_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state_q  <= RX_BITS;
              if (phase_q == PH_ADDR)     phase_q <= PH_PTR;
              else if (phase_q == PH_PTR) phase_q <= PH_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/audio_reg_bank.sv
module audio_reg_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MUTE_REG = 7,
  parameter int unsigned MUTE_BIT = 7,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_stb_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o,
  output logic                             wr_pulse_o,
  output logic [IDX_W-1:0]                 wr_addr_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (g == MUTE_REG) ? (DATA_W'(1) << MUTE_BIT) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= RST_VAL;
      else if (wr_stb_i && wr_idx_i == IDX_W'(g))   mem_q[g] <= wr_data_i;
    end

    assign regs_o[g] = mem_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pulse_o <= 1'b0;
      wr_addr_o  <= '0;
    end else begin
      wr_pulse_o <= wr_stb_i;
      if (wr_stb_i) wr_addr_o <= wr_idx_i;
    end
  end
endmodule

// File: rtl/audio_fader_i2c_slave.sv
module audio_fader_i2c_slave
  import audio_i2c_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR    = 8'h80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [VOL_W-1:0]   volume_o,
  output logic               loud_en_o,
  output logic               zc_mode_o,
  output logic [FADER_W-1:0] fader_fr_o,
  output logic [FADER_W-1:0] fader_fl_o,
  output logic [FADER_W-1:0] fader_rr_o,
  output logic [FADER_W-1:0] fader_rl_o,
  output logic [TONE_W-1:0]  bass_o,
  output logic [TONE_W-1:0]  treble_o,
  output logic               gen_mute_o,
  output logic [SRC_W-1:0]   src_sel_o,
  output logic               wr_pulse_o,
  output logic [IDX_W-1:0]   wr_addr_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb;
  logic [IDX_W-1:0] wr_idx;
  logic [REG_W-1:0] wr_data;
  logic [NUM_REGS-1:0][REG_W-1:0] regs_w;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_write_rx #(.DATA_W(REG_W), .PTR_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  audio_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (REG_W),
    .MUTE_REG (REG_SW),
    .MUTE_BIT (MUTE_BIT)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .regs_o     (regs_w),
    .wr_pulse_o (wr_pulse_o),
    .wr_addr_o  (wr_addr_o)
  );

  assign zc_mode_o  = regs_w[REG_VOL][7];
  assign loud_en_o  = ~regs_w[REG_VOL][6];
  assign volume_o   = regs_w[REG_VOL][VOL_W-1:0];
  assign fader_fr_o = regs_w[REG_FR][FADER_W-1:0];
  assign fader_fl_o = regs_w[REG_FL][FADER_W-1:0];
  assign fader_rr_o = regs_w[REG_RR][FADER_W-1:0];
  assign fader_rl_o = regs_w[REG_RL][FADER_W-1:0];
  assign bass_o     = regs_w[REG_BASS][TONE_W-1:0];
  assign treble_o   = regs_w[REG_TREB][TONE_W-1:0];
  assign gen_mute_o = regs_w[REG_SW][MUTE_BIT];
  assign src_sel_o  = regs_w[REG_SW][SRC_W-1:0];
endmodule

// File: rtl/audio_fader_i2c_chk.sv
module audio_fader_i2c_chk #(
  parameter int unsigned BANK_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              stop_i,
  input logic              sda_oe_i,
  input logic              wr_pulse_i,
  input logic              gen_mute_i,
  input logic [BANK_W-1:0] bank_i
);
  assert_pulse_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_i |=> !wr_pulse_i);

  assert_bank_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pulse_i |-> $stable(bank_i));

  assert_release_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  assert_sda_steady_scl_high_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(sda_oe_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_mute_in_reset_R10: assert (gen_mute_i && !sda_oe_i);
    end
  end
endmodule

bind audio_fader_i2c_slave audio_fader_i2c_chk #(.BANK_W(64)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s_i    (scl_s),
  .stop_i     (stop_det),
  .sda_oe_i   (sda_oe_o),
  .wr_pulse_i (wr_pulse_o),
  .gen_mute_i (gen_mute_o),
  .bank_i     (regs_w)
);

// File: tb/audio_fader_i2c_slave_test.sv
`timescale 1ns/1ps
module audio_fader_i2c_slave_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [5:0] volume, ffr, ffl, frr, frl;
  logic [4:0] bass, treble;
  logic loud_en, zc_mode, gen_mute, wr_pulse;
  logic [2:0] src_sel, wr_addr;

  always #2 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  audio_fader_i2c_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .volume_o(volume), .loud_en_o(loud_en), .zc_mode_o(zc_mode),
    .fader_fr_o(ffr), .fader_fl_o(ffl), .fader_rr_o(frr), .fader_rl_o(frl),
    .bass_o(bass), .treble_o(treble), .gen_mute_o(gen_mute), .src_sel_o(src_sel),
    .wr_pulse_o(wr_pulse), .wr_addr_o(wr_addr)
  );

  typedef struct { logic [2:0] idx; logic [7:0] val; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] sb_ptr = '0;
  logic ack;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] field_mask(input logic [2:0] i);
    case (i)
      3'd0:       return 8'hFF;
      3'd5, 3'd6: return 8'h1F;
      3'd7:       return 8'h87;
      default:    return 8'h3F;
    endcase
  endfunction

  function automatic logic [7:0] readback(input logic [2:0] i);
    case (i)
      3'd0: return {zc_mode, ~loud_en, volume};
      3'd1: return {2'b0, ffr};
      3'd2: return {2'b0, ffl};
      3'd3: return {2'b0, frr};
      3'd4: return {2'b0, frl};
      3'd5: return {3'b0, bass};
      3'd6: return {3'b0, treble};
      default: return {gen_mute, 4'b0, src_sel};
    endcase
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; wait_q();
    scl_drv = 1'b1; wait_q();
    sda_drv = 1'b0; wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wait_q();
    scl_drv = 1'b1; wait_q();
    sda_drv = 1'b1; wait_q();
  endtask

  task automatic send_bit(input logic v);
    sda_drv = v;    wait_q();
    scl_drv = 1'b1; wait_q(); wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; wait_q();
    scl_drv = 1'b1; wait_q();
    a = ~sda_line;  wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic open_xfer(input logic [7:0] ptr);
    i2c_start();
    send_byte(8'h80, ack); check("R2 address ack", ack, 1);
    send_byte(ptr, ack);   check("R3 pointer ack", ack, 1);
    sb_ptr = ptr[2:0];
  endtask

  task automatic data_byte(input logic [7:0] b);
    exp_t e;
    e.idx = sb_ptr;
    e.val = b & field_mask(sb_ptr);
    exp_q.push_back(e);
    sb_ptr = sb_ptr + 3'd1;
    send_byte(b, ack); check("R4 data ack", ack, 1);
  endtask

  // scoreboard monitor
  logic pulse_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse_prev) check("R11 pulse width", wr_pulse, 0);
      if (wr_pulse) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R9 unexpected write: actual idx %0d expected none", wr_addr);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R5 write index", wr_addr, e.idx);
          check("R4 stored value", readback(wr_addr) & field_mask(wr_addr), e.val);
        end
      end
      pulse_prev <= wr_pulse;
    end else begin
      pulse_prev <= 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 mute in reset", gen_mute, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 volume", volume, 0);
    check("R1 loudness", loud_en, 1);
    check("R1 zero-cross", zc_mode, 0);
    check("R1 general mute", gen_mute, 1);
    check("R1 faders", {ffr, ffl, frr, frl}, 0);
    check("R1 tone/src", {bass, treble, src_sel}, 0);
    check("R1 sda released", sda_oe, 0);
    check("R1 no strobe", wr_pulse, 0);

    // volume and front right
    open_xfer(8'h00);
    data_byte(8'hC5);
    data_byte(8'h2A);
    i2c_stop();
    check("R9 sda released after stop", sda_oe, 0);
    check("R6 zero-cross bit", zc_mode, 1);
    check("R6 loudness off", loud_en, 0);
    check("R6 volume", volume, 5);
    check("R7 front right", ffr, 6'h2A);

    // burst from bass through wrap
    open_xfer(8'h05);
    data_byte(8'hFF);
    data_byte(8'hEA);
    data_byte(8'h7F);
    data_byte(8'h13);
    data_byte(8'h01);
    i2c_stop();
    check("R7 bass width", bass, 5'h1F);
    check("R7 treble width", treble, 5'h0A);
    check("R8 mute cleared", gen_mute, 0);
    check("R8 source", src_sel, 7);
    check("R5 wrap to volume", volume, 6'h13);
    check("R5 wrap zc", zc_mode, 0);
    check("R5 wrap front right", ffr, 6'h01);

    // upper pointer bits ignored
    open_xfer(8'hFB);
    data_byte(8'h11);
    i2c_stop();
    check("R3 upper pointer bits ignored", frr, 6'h11);

    // foreign address
    i2c_start();
    send_byte(8'h82, ack); check("R2 foreign address nack", ack, 0);
    send_byte(8'h02, ack); check("R2 ignored pointer nack", ack, 0);
    send_byte(8'h3F, ack); check("R2 ignored data nack", ack, 0);
    i2c_stop();
    check("R2 front left untouched", ffl, 0);

    // bytes after stop
    open_xfer(8'h04);
    data_byte(8'h07);
    i2c_stop();
    send_byte(8'h99, ack); check("R9 byte after stop nack", ack, 0);
    check("R9 rear left kept", frl, 7);

    // repeated start
    open_xfer(8'h02);
    data_byte(8'h05);
    i2c_start();
    send_byte(8'h04, ack); check("R9 restart needs address", ack, 0);
    send_byte(8'h04, ack); check("R9 restart data ignored", ack, 0);
    check("R9 front left kept", ffl, 5);
    open_xfer(8'h06);
    data_byte(8'h03);
    i2c_stop();
    check("R9 write after restart", treble, 3);

    // reset in mid-byte
    open_xfer(8'h07);
    data_byte(8'h02);
    check("R8 source two", src_sel, 2);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 mute forced", gen_mute, 1);
    check("R10 sda released", sda_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_bit(1'b0); send_bit(1'b0);
    i2c_stop();
    check("R10 source cleared", src_sel, 0);
    check("R10 mute stays", gen_mute, 1);
    open_xfer(8'h07);
    data_byte(8'h02);
    i2c_stop();
    check("R10 recovers mute", gen_mute, 0);

    repeat (20) @(negedge clk);
    check("R4 all writes seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule